// File: doc/BRIEF.md
# Masked-Access GPIO Bank with Interrupt Detection

This block is one bank of eight general-purpose pins behind a simple byte-wide register bus. Each pin can be an input or a driven output, or it can be handed to another hardware function, which then supplies the pin's output value and output enable. The data and direction registers take a per-pin mask from the access address. Software can therefore set, clear or sample any subset of pins in one bus cycle, with no read-modify-write.

Every pin input passes through a two-flop synchronizer and feeds an interrupt detector. The detector can be level or edge sensitive, with a selectable polarity, and it has a both-edges option. Software sees a raw status and an enable-masked status. It clears latched edge events by writing ones. One registered interrupt line is the OR of all masked status bits.

Top module: `gpio_irq_bank`

## Requirements
- R1: After synchronous reset every register is 0. All pins are inputs with no hardware hand-over, `pin_oe` and `pin_out` are 0, interrupts are disabled and `irq` is 0.
- R2: A write with address bits [11:10] = 00 updates the data bit of pin i only where address bit i+2 is 1. Unselected pins keep their value. For a pin not handed over, `pin_out` shows its data bit.
- R3: A read with address bits [11:10] = 00 returns 0 for pins whose address bit i+2 is 0. For a selected pin it returns the data bit if the pin is an output, and the synchronized input level if the pin is an input.
- R4: Address bits [11:10] = 10 reach the direction register with the same address masking. A direction bit of 1 drives `pin_oe` high for that pin (1 = output, 0 = input).
- R5: A 1 in the hand-over register (offset 0x420) routes `alt_out`/`alt_oe` to `pin_out`/`pin_oe` for that pin. Data and direction bits then have no effect on that pin.
- R6: With the sense register (0x404) bit at 1, the pin is level sensitive. Its raw status equals the synchronized level when the event register (0x40C) bit is 1, and the inverted level when that bit is 0. Writing the clear register does not change it.
- R7: With sense bit 0, the pin is edge sensitive. A rising edge (event bit 1) or a falling edge (event bit 0) sets a latched raw status bit. The bit holds until a 1 is written to that pin's bit of the clear register (0x41C). A new edge in the same cycle wins over the clear.
- R8: With the both-edges register (0x408) bit at 1 on an edge-sensitive pin, rising and falling transitions both set the status. The event bit is then ignored.
- R9: Offset 0x414 reads raw status whatever the enable register (0x410) holds. Offset 0x418 reads raw AND enable. Writes to both offsets have no effect.
- R10: `irq` is a register and equals, one cycle later, the OR over all pins of raw status AND enable.
- R11: A write to any offset in the 0x400 page other than the defined ones, or to any address with bits [11:10] = 11, changes nothing. A read from such an address returns 0.
- R12: `bus_rdata` is registered. It carries the read value in the cycle after `bus_re` is sampled high, and 0 after a cycle without `bus_re`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| alt_out | input | 8 | Output values from the hardware function |
| alt_oe | input | 8 | Output enables from the hardware function |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the bank with its defaults: eight pins and a two-stage synchronizer. With these values the full 12-bit address map is reached, every mask pattern in address bits [9:2] can be tried, and the exact three-cycle path from a pin change to a latched edge is exposed. A behavioural model runs in step with the bank and steers directed sequences through each detection mode, hand-over, masked access and unmapped offsets. Hand-computed reads at chosen points check the model itself.

// File: rtl/gpb_pkg.sv
// Package: shared constants and types for the GPIO bank.
// Assumes a 12-bit byte address; bits [11:10] select the region.
package gpb_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h41C;
    localparam logic [ADDR_W-1:0] OFS_ALTSEL = 12'h420;

    typedef enum logic [1:0] {
        RGN_DATA = 2'b00,
        RGN_CTRL = 2'b01,
        RGN_DIR  = 2'b10,
        RGN_NONE = 2'b11
    } region_e;
endpackage

// File: rtl/gpb_sync.sv
// Module: gpb_sync
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency needed).
module gpb_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Purpose: pass the sample down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpb_detect.sv
// Module: gpb_detect
// Per-pin interrupt detection: level or edge, polarity, both edges.
// Edges are found by comparing the synchronized level with the previous
// sample. Edge status latches until cleared; level status is live.
// Assumes lvl is already synchronous to clk.
module gpb_detect #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] sense,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] evt,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] edge_lat
);
    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            logic prev_q;
            logic rise;
            logic fall;
            logic hit;

            // Purpose: remember the previous synchronized level.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= lvl[i];
            end

            // Purpose: classify the transition and pick the active edge.
            always_comb begin
                rise = lvl[i] & ~prev_q;
                fall = ~lvl[i] & prev_q;
                if (both[i]) hit = rise | fall;
                else         hit = evt[i] ? rise : fall;
            end

            // Purpose: latch edge events; a new event beats a clear.
            always_ff @(posedge clk) begin
                if (!rst_n)   edge_lat[i] <= 1'b0;
                else if (hit) edge_lat[i] <= 1'b1;
                else if (clr[i]) edge_lat[i] <= 1'b0;
            end

            // Purpose: select live level status or latched edge status.
            always_comb begin
                if (sense[i]) raw[i] = ~(lvl[i] ^ evt[i]);
                else          raw[i] = edge_lat[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpb_regs.sv
// Module: gpb_regs
// Register file and address decode for the GPIO bank. Data and direction
// accesses use address bits [NPINS+1:2] as a pin mask. Read data is
// registered and is zero after a cycle without a read.
// Assumes NPINS <= 8 so the mask stays below the region bits [11:10].
module gpb_regs
    import gpb_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    input  logic              we,
    input  logic              re,
    input  logic [NPINS-1:0]  pin_sync,
    input  logic [NPINS-1:0]  raw_st,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  evt_q,
    output logic [NPINS-1:0]  en_q,
    output logic [NPINS-1:0]  af_q,
    output logic [NPINS-1:0]  clr_vec,
    output logic [NPINS-1:0]  rdata
);
    localparam int MSB = NPINS + 1;

    region_e          rgn;
    logic [NPINS-1:0] sel;
    logic [NPINS-1:0] rd_val;
    logic             wr_data, wr_dir, wr_sense, wr_both, wr_evt, wr_en, wr_af;

    // Purpose: split the address into region and pin mask.
    always_comb begin
        rgn = region_e'(addr[ADDR_W-1:ADDR_W-2]);
        sel = addr[MSB:2];
    end

    // Purpose: decode write strobes for each register.
    always_comb begin
        wr_data  = we && (rgn == RGN_DATA);
        wr_dir   = we && (rgn == RGN_DIR);
        wr_sense = we && (addr == OFS_SENSE);
        wr_both  = we && (addr == OFS_BOTH);
        wr_evt   = we && (addr == OFS_EVENT);
        wr_en    = we && (addr == OFS_ENABLE);
        wr_af    = we && (addr == OFS_ALTSEL);
        clr_vec  = (we && (addr == OFS_CLEAR)) ? wdata : '0;
    end

    // Purpose: masked update of data and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_data) data_q <= (data_q & ~sel) | (wdata & sel);
            if (wr_dir)  dir_q  <= (dir_q & ~sel) | (wdata & sel);
        end
    end

    // Purpose: whole-byte update of control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            both_q  <= '0;
            evt_q   <= '0;
            en_q    <= '0;
            af_q    <= '0;
        end else begin
            if (wr_sense) sense_q <= wdata;
            if (wr_both)  both_q  <= wdata;
            if (wr_evt)   evt_q   <= wdata;
            if (wr_en)    en_q    <= wdata;
            if (wr_af)    af_q    <= wdata;
        end
    end

    // Purpose: select the read value for the current address.
    always_comb begin
        rd_val = '0;
        unique case (rgn)
            RGN_DATA: rd_val = sel & ((dir_q & data_q) | (~dir_q & pin_sync));
            RGN_DIR:  rd_val = sel & dir_q;
            RGN_CTRL: begin
                case (addr)
                    OFS_SENSE:  rd_val = sense_q;
                    OFS_BOTH:   rd_val = both_q;
                    OFS_EVENT:  rd_val = evt_q;
                    OFS_ENABLE: rd_val = en_q;
                    OFS_RAW:    rd_val = raw_st;
                    OFS_MASKED: rd_val = raw_st & en_q;
                    OFS_ALTSEL: rd_val = af_q;
                    default:    rd_val = '0;
                endcase
            end
            default:  rd_val = '0;
        endcase
    end

    // Purpose: register read data; zero when no read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= rd_val;
        else         rdata <= '0;
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// Module: gpio_irq_bank
// Top of the GPIO bank: synchronizer, detectors, register file, pin
// output mux and the registered combined interrupt.
// Assumes a single clock domain for the bus; pin_in is asynchronous.
module gpio_irq_bank
    import gpb_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] data_q, dir_q, sense_q, both_q, evt_q, en_q, af_q;
    logic [NPINS-1:0] clr_vec, raw_st, edge_lat;
    logic             irq_q;

    gpb_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpb_detect #(.NPINS(NPINS)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (pin_sync),
        .sense    (sense_q),
        .both     (both_q),
        .evt      (evt_q),
        .clr      (clr_vec),
        .raw      (raw_st),
        .edge_lat (edge_lat)
    );

    gpb_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .re       (bus_re),
        .pin_sync (pin_sync),
        .raw_st   (raw_st),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .sense_q  (sense_q),
        .both_q   (both_q),
        .evt_q    (evt_q),
        .en_q     (en_q),
        .af_q     (af_q),
        .clr_vec  (clr_vec),
        .rdata    (bus_rdata)
    );

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pad
            // Purpose: give the pin to the hardware function or the bank.
            always_comb begin
                pin_out[i] = af_q[i] ? alt_out[i] : data_q[i];
                pin_oe[i]  = af_q[i] ? alt_oe[i]  : dir_q[i];
            end
        end
    endgenerate

    // Purpose: register the OR of all enabled status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(raw_st & en_q);
    end

    assign irq = irq_q;
endmodule

// File: rtl/gpb_checker.sv
// Module: gpb_checker
// Temporal properties of the GPIO bank, attached by bind.
// Assumes reset is held for at least one clock at start.
module gpb_checker #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_re,
    input logic [NPINS-1:0] bus_rdata,
    input logic             irq,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] af_q,
    input logic [NPINS-1:0] sense_q,
    input logic [NPINS-1:0] evt_q,
    input logic [NPINS-1:0] en_q,
    input logic [NPINS-1:0] raw_st,
    input logic [NPINS-1:0] edge_lat,
    input logic [NPINS-1:0] clr_vec,
    input logic [NPINS-1:0] pin_sync
);
    AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(raw_st & en_q)))); // R10

    AST_LEVEL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((sense_q & (raw_st ^ ~(pin_sync ^ evt_q))) == '0)); // R6

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(edge_lat) & ~$past(clr_vec)) & ~edge_lat) == '0)); // R7

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0)); // R12

    AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~af_q & pin_oe) == '0)); // R4
endmodule

bind gpio_irq_bank gpb_checker #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .pin_oe    (pin_oe),
    .dir_q     (dir_q),
    .af_q      (af_q),
    .sense_q   (sense_q),
    .evt_q     (evt_q),
    .en_q      (en_q),
    .raw_st    (raw_st),
    .edge_lat  (edge_lat),
    .clr_vec   (clr_vec),
    .pin_sync  (pin_sync)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  alt_out = '0;
    logic [7:0]  alt_oe = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gpio_irq_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Behavioural reference model state
    logic [7:0] m_data, m_dir, m_sense, m_both, m_evt, m_en, m_af, m_edge;
    logic [7:0] m_s1, m_s2, m_s3, m_rd;
    logic       m_irq;

    function automatic logic [7:0] m_raw();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = m_sense[i] ? (m_evt[i] ? m_s2[i] : !m_s2[i]) : m_edge[i];
        return r;
    endfunction

    function automatic logic [7:0] m_read(input logic [11:0] a);
        logic [7:0] sel;
        logic [7:0] v;
        sel = a[9:2];
        v = 8'h00;
        if (a[11:10] == 2'b00) begin
            for (int i = 0; i < 8; i++)
                if (sel[i]) v[i] = m_dir[i] ? m_data[i] : m_s2[i];
        end else if (a[11:10] == 2'b10) begin
            v = m_dir & sel;
        end else if (a == 12'h404) v = m_sense;
        else if (a == 12'h408) v = m_both;
        else if (a == 12'h40C) v = m_evt;
        else if (a == 12'h410) v = m_en;
        else if (a == 12'h414) v = m_raw();
        else if (a == 12'h418) v = m_raw() & m_en;
        else if (a == 12'h420) v = m_af;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data <= 0; m_dir <= 0; m_sense <= 0; m_both <= 0; m_evt <= 0;
            m_en <= 0; m_af <= 0; m_edge <= 0; m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
            m_rd <= 0; m_irq <= 0;
        end else begin
            m_s1 <= pin_in; m_s2 <= m_s1; m_s3 <= m_s2;
            for (int i = 0; i < 8; i++) begin
                bit up, dn, ev;
                up = m_s2[i] && !m_s3[i];
                dn = !m_s2[i] && m_s3[i];
                ev = m_both[i] ? (up || dn) : (m_evt[i] ? up : dn);
                if (ev) m_edge[i] <= 1'b1;
                else if (bus_we && bus_addr == 12'h41C && bus_wdata[i]) m_edge[i] <= 1'b0;
                if (bus_we && bus_addr[11:10] == 2'b00 && bus_addr[i+2]) m_data[i] <= bus_wdata[i];
                if (bus_we && bus_addr[11:10] == 2'b10 && bus_addr[i+2]) m_dir[i] <= bus_wdata[i];
            end
            if (bus_we && bus_addr == 12'h404) m_sense <= bus_wdata;
            if (bus_we && bus_addr == 12'h408) m_both  <= bus_wdata;
            if (bus_we && bus_addr == 12'h40C) m_evt   <= bus_wdata;
            if (bus_we && bus_addr == 12'h410) m_en    <= bus_wdata;
            if (bus_we && bus_addr == 12'h420) m_af    <= bus_wdata;
            m_irq <= |(m_raw() & m_en);
            m_rd  <= bus_re ? m_read(bus_addr) : 8'h00;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 R5 pin_out", pin_out, (m_af & alt_out) | (~m_af & m_data));
            chk("R4 R5 pin_oe", pin_oe, (m_af & alt_oe) | (~m_af & m_dir));
            chk("R3 R9 R12 bus_rdata", bus_rdata, m_rd);
            chk("R10 irq", {7'b0, irq}, {7'b0, m_irq});
        end
    end

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        @(negedge clk); #1;
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        v = bus_rdata;
        #1 bus_re = 1'b0;
    endtask

    task automatic pins(input logic [7:0] p);
        @(negedge clk); #1;
        pin_in = p;
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rd(12'h414, v); chk("R1 raw", v, 8'h00);
        rd(12'h420, v); chk("R1 altsel", v, 8'h00);

        // R4 / R2: masked direction and data writes
        wr(12'hBFC, 8'h0F);
        chk("R4 oe", pin_oe, 8'h0F);
        wr(12'h014, 8'hFF);
        chk("R2 out mask 05", pin_out, 8'h05);
        wr(12'h00C, 8'h02);
        chk("R2 out mask 03", pin_out, 8'h06);
        rd(12'h83C, v); chk("R4 dir read masked", v, 8'h0F);

        // R3: masked data read mixes outputs and synchronized inputs
        pins(8'hF0);
        rd(12'h0F0, v); chk("R3 read mask 3C", v, 8'h34);
        rd(12'h004, v); chk("R3 read mask 01", v, 8'h00);

        // R5: hand-over to hardware function
        alt_out = 8'hAA; alt_oe = 8'hF0;
        wr(12'h420, 8'h81);
        chk("R5 out", pin_out, 8'h86);
        chk("R5 oe", pin_oe, 8'h8E);
        wr(12'h004, 8'h01);
        chk("R5 data ignored", pin_out, 8'h86);
        wr(12'h420, 8'h00);
        chk("R5 released", pin_out, 8'h07);

        // R6 / R9 / R10: level mode on pin 4
        wr(12'h404, 8'h10);
        wr(12'h40C, 8'h10);
        rd(12'h414, v); chk("R6 level raw", v, 8'h10);
        rd(12'h418, v); chk("R9 masked none", v, 8'h00);
        wr(12'h41C, 8'hFF);
        rd(12'h414, v); chk("R6 clear no effect", v, 8'h10);
        wr(12'h410, 8'h10);
        rd(12'h418, v); chk("R9 masked", v, 8'h10);
        chk("R10 irq high", {7'b0, irq}, 8'h01);
        pins(8'hE0);
        rd(12'h414, v); chk("R6 level follows", v, 8'h00);
        chk("R10 irq low", {7'b0, irq}, 8'h00);

        // R7: rising edge on pin 5 latches
        wr(12'h40C, 8'h30);
        pins(8'hC0);
        rd(12'h414, v); chk("R7 wrong edge", v, 8'h00);
        pins(8'hE0);
        pins(8'hC0);
        rd(12'h414, v); chk("R7 latched", v, 8'h20);
        wr(12'h41C, 8'h20);
        rd(12'h414, v); chk("R7 cleared", v, 8'h00);

        // R8: both edges on pin 6
        wr(12'h408, 8'h40);
        pins(8'h80);
        rd(12'h414, v); chk("R8 fall", v, 8'h40);
        wr(12'h41C, 8'h40);
        pins(8'hC0);
        rd(12'h414, v); chk("R8 rise", v, 8'h40);
        wr(12'h41C, 8'hFF);

        // R11 / R9: unmapped and read-only offsets
        wr(12'h424, 8'hFF);
        wr(12'h400, 8'hFF);
        wr(12'hC10, 8'hFF);
        wr(12'h414, 8'hFF);
        rd(12'h424, v); chk("R11 read 424", v, 8'h00);
        rd(12'hC10, v); chk("R11 read C10", v, 8'h00);
        rd(12'h404, v); chk("R11 sense kept", v, 8'h10);
        rd(12'h414, v); chk("R9 raw read-only", v, 8'h00);
        chk("R11 out kept", pin_out, 8'h07);

        // R12: idle bus reads zero
        @(negedge clk);
        chk("R12 idle rdata", bus_rdata, 8'h00);

        repeat (3) @(negedge clk);
        done = 1;
        summary();
    end
endmodule